// File: doc/BRIEF.md
# Serial Transmit Framer with Programmable Character Format

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A 7-bit line control word sets the frame: character length (5 to 8 bits), whether a parity bit is sent, and whether that parity is odd, even or a fixed constant. It also sets the length of the stop period and a break override that pulls the line low. A baud tick from outside paces the frame at 16 ticks per bit time. Because of this rate, a stop period can be one and a half bits long.

A character is offered with `tx_valid` and taken when `tx_ready` is high. The frame format is captured together with the character. The break override is the one exception: it acts on the pin at once and never changes the sequencer's timing.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset and between frames, `tx_out` is 1, `tx_ready` is 1 and `tx_busy` is 0.
- R2: An accepted frame starts with a start bit at 0 lasting 16 baud ticks. The data bits follow, least significant first, each lasting 16 ticks.
- R3: Character length comes from `line_ctrl[7:6]`: 00 gives 5 bits, 10 gives 6 bits, 01 gives 7 bits and 11 gives 8 bits. Data bits above the selected length are ignored.
- R4: With `line_ctrl[4]`=1 and `line_ctrl[2]`=0, one parity bit of 16 ticks follows the last data bit. If `line_ctrl[3]`=1 the data bits plus the parity bit hold an even number of ones. If `line_ctrl[3]`=0 they hold an odd number.
- R5: With `line_ctrl[4]`=1 and `line_ctrl[2]`=1, the parity bit is the constant NOT `line_ctrl[3]`.
- R6: With `line_ctrl[4]`=0, no parity bit is sent, whatever the values of `line_ctrl[3]` and `line_ctrl[2]`.
- R7: The stop period is held at 1. It lasts 16 ticks when `line_ctrl[5]`=0. When `line_ctrl[5]`=1 it lasts 24 ticks for a 5-bit character and 32 ticks for any other length.
- R8: While `line_ctrl[1]`=1, `tx_out` is 0. The frame timing and the handshake carry on as if the break were absent.
- R9: A character is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low and `tx_busy` stays high from acceptance until the last stop tick, so no second character is taken during a frame.
- R10: Format bits 7:2 are captured when the character is accepted. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| line_ctrl | input | 7 | Format word, bits 7:1 (length, stop, parity enable/even/stick, break) |
| tx_data | input | 8 | Character to send, LSB first |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Framer idle and able to accept |
| tx_busy | output | 1 | Frame in progress |
| tx_out | output | 1 | Serial line, idle high |

## Verification
The assertions check, on every cycle, these invariants: the start bit follows acceptance, the captured format holds through a frame, the data-bit index stays within the selected length, the parity bit has the right sum for odd or even parity or is the right constant in stick mode, and `tx_ready` drops after each acceptance. The exact tick length of each bit, including the 24-tick stop period, and the lines that break pulls low while the frame timing stays the same, are shown only by the bench. Its behavioural model builds every frame as a list of (level, duration) segments and compares the line and handshake on each clock. The same holds for the sweep over every length, parity mode and stop choice, and for format changes made in the middle of a frame.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;

  localparam int CHAR_W = 8;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    logic       even;
    logic       stick;
    logic       stop_long;
  } fmt_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } seq_t;

  // sel = {line bit 7, line bit 6}
  function automatic logic [3:0] len_from_sel(logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd5;
      2'b10:   return 4'd6;
      2'b01:   return 4'd7;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [CHAR_W-1:0] low_mask(logic [3:0] n);
    logic [CHAR_W:0] one_hot;
    one_hot = (CHAR_W+1)'(1) << n;
    return CHAR_W'(one_hot - (CHAR_W+1)'(1));
  endfunction

  function automatic logic parity_bit(logic [CHAR_W-1:0] d, fmt_t f);
    if (f.stick) return ~f.even;
    return (^(d & low_mask(f.nbits))) ^ ~f.even;
  endfunction

  function automatic int stop_ticks(fmt_t f, int tpb);
    if (!f.stop_long)      return tpb;
    if (f.nbits == 4'd5)   return tpb + tpb / 2;
    return 2 * tpb;
  endfunction

endpackage

// File: rtl/uart_tx_fmt_decode.sv
`timescale 1ns/1ps
module uart_tx_fmt_decode
  import uart_tx_pkg::*;
(
  input  logic [7:1] line_ctrl,
  output fmt_t       fmt,
  output logic       brk
);
  always_comb begin
    fmt.nbits     = len_from_sel({line_ctrl[7], line_ctrl[6]});
    fmt.stop_long = line_ctrl[5];
    fmt.par_en    = line_ctrl[4];
    fmt.even      = line_ctrl[3];
    fmt.stick     = line_ctrl[2];
    brk           = line_ctrl[1];
  end
endmodule

// File: rtl/uart_tx_parity.sv
`timescale 1ns/1ps
module uart_tx_parity
  import uart_tx_pkg::*;
(
  input  logic [CHAR_W-1:0] data,
  input  fmt_t              fmt,
  output logic [CHAR_W-1:0] data_masked,
  output logic              par_bit
);
  always_comb begin
    data_masked = data & low_mask(fmt.nbits);
    par_bit     = parity_bit(data_masked, fmt);
  end
endmodule

// File: rtl/uart_tx_seq.sv
`timescale 1ns/1ps
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter int TPB = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              accept,
  input  fmt_t              fmt_in,
  input  logic [CHAR_W-1:0] data_in,
  input  logic              par_in,
  output logic              line_bit,
  output logic              idle,
  output logic              frame_end
);
  localparam int CW = $clog2(2 * TPB);

  seq_t              state;
  fmt_t              fmt_q;
  logic [CHAR_W-1:0] shreg;
  logic [CHAR_W-1:0] data_q;
  logic              par_q;
  logic [3:0]        bit_idx;
  logic [CW-1:0]     tick_cnt;

  int   phase_len;
  logic phase_end;
  logic last_bit;

  always_comb begin
    phase_len = (state == S_STOP) ? stop_ticks(fmt_q, TPB) : TPB;
    phase_end = baud_tick && (int'(tick_cnt) == phase_len - 1);
    last_bit  = (bit_idx == fmt_q.nbits - 4'd1);
    frame_end = (state == S_STOP) && phase_end;
    idle      = (state == S_IDLE);
    case (state)
      S_START: line_bit = 1'b0;
      S_DATA:  line_bit = shreg[0];
      S_PAR:   line_bit = par_q;
      default: line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      fmt_q    <= '0;
      shreg    <= '0;
      data_q   <= '0;
      par_q    <= 1'b0;
      bit_idx  <= '0;
      tick_cnt <= '0;
    end else if (state == S_IDLE) begin
      if (accept) begin
        state    <= S_START;
        fmt_q    <= fmt_in;
        shreg    <= data_in;
        data_q   <= data_in;
        par_q    <= par_in;
        bit_idx  <= '0;
        tick_cnt <= '0;
      end
    end else if (phase_end) begin
      tick_cnt <= '0;
      case (state)
        S_START: state <= S_DATA;
        S_DATA: begin
          shreg   <= {1'b0, shreg[CHAR_W-1:1]};
          bit_idx <= bit_idx + 4'd1;
          if (last_bit) state <= fmt_q.par_en ? S_PAR : S_STOP;
        end
        S_PAR:   state <= S_STOP;
        default: state <= S_IDLE;
      endcase
    end else if (baud_tick) begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  // R2: acceptance is followed by the start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state == S_START && line_bit == 1'b0));

  // R10: captured format frozen while a frame runs
  p_fmt_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !frame_end) |=> $stable(fmt_q));

  // R3: data index bounded by selected length
  p_bits_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA) |-> (bit_idx < fmt_q.nbits));

  // R4: parity sum over the sent bits
  p_par_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && fmt_q.par_en && !fmt_q.stick)
      |-> (($countones({data_q, par_q}) % 2) == (fmt_q.even ? 0 : 1)));

  // R5: stick parity constant
  p_stick_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && fmt_q.par_en && fmt_q.stick) |-> (par_q == ~fmt_q.even));

endmodule

// File: rtl/uart_tx_framer.sv
`timescale 1ns/1ps
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [7:1]        line_ctrl,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_busy,
  output logic              tx_out
);
  fmt_t              fmt_now;
  logic              brk_now;
  logic [CHAR_W-1:0] data_masked;
  logic              par_now;
  logic              line_bit;
  logic              seq_idle;
  logic              frame_end;
  logic              accept;

  uart_tx_fmt_decode u_dec (
    .line_ctrl (line_ctrl),
    .fmt       (fmt_now),
    .brk       (brk_now)
  );

  uart_tx_parity u_par (
    .data        (tx_data),
    .fmt         (fmt_now),
    .data_masked (data_masked),
    .par_bit     (par_now)
  );

  assign accept = tx_valid && seq_idle;

  uart_tx_seq #(.TPB(TICKS_PER_BIT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .accept    (accept),
    .fmt_in    (fmt_now),
    .data_in   (data_masked),
    .par_in    (par_now),
    .line_bit  (line_bit),
    .idle      (seq_idle),
    .frame_end (frame_end)
  );

  assign tx_ready = seq_idle;
  assign tx_busy  = ~seq_idle;
  assign tx_out   = brk_now ? 1'b0 : line_bit;

  // R9: one acceptance closes the door until the frame ends
  p_accept_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R7: ready returns only through the end of a stop period
  p_ready_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !frame_end) |=> tx_busy);

endmodule

// File: tb/sim_uart_tx_framer.sv
`timescale 1ns/1ps
module sim_uart_tx_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:1] line_ctrl = '0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       baud_tick;
  logic       tx_ready, tx_busy, tx_out;

  always #2 clk = ~clk;

  int bc = 0;
  always @(negedge clk) bc <= (bc == 2) ? 0 : bc + 1;
  assign baud_tick = (bc == 0);

  uart_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .line_ctrl(line_ctrl),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_busy(tx_busy), .tx_out(tx_out)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string scen = "R1";
  int    lvl_q[$];
  int    dur_q[$];
  string tag_q[$];
  int    seg_cnt = 0;

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s scen=%s %s actual=%b expected=%b t=%0t", req, scen, what, act, exp, $time);
    end
  endtask

  // frame as a list of (level, ticks) segments
  function automatic void build(logic [7:1] lc, logic [7:0] d);
    int n, ones, par;
    case ({lc[7], lc[6]})
      2'b00: n = 5;
      2'b10: n = 6;
      2'b01: n = 7;
      default: n = 8;
    endcase
    lvl_q.push_back(0); dur_q.push_back(16); tag_q.push_back("R2");
    ones = 0;
    for (int i = 0; i < n; i++) begin
      lvl_q.push_back(int'(d[i])); dur_q.push_back(16); tag_q.push_back("R3");
      ones += int'(d[i]);
    end
    if (lc[4]) begin
      if (lc[2]) begin
        par = lc[3] ? 0 : 1;
        tag_q.push_back("R5");
      end else begin
        par = lc[3] ? (ones % 2) : 1 - (ones % 2);
        tag_q.push_back("R4");
      end
      lvl_q.push_back(par); dur_q.push_back(16);
    end
    lvl_q.push_back(1);
    dur_q.push_back(!lc[5] ? 16 : (n == 5 ? 24 : 32));
    tag_q.push_back("R7");
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      lvl_q.delete(); dur_q.delete(); tag_q.delete(); seg_cnt = 0;
    end else if (lvl_q.size() == 0) begin
      if (tx_valid) begin
        build(line_ctrl, tx_data);
        seg_cnt = 0;
      end
    end else if (baud_tick) begin
      seg_cnt++;
      if (seg_cnt == dur_q[0]) begin
        void'(lvl_q.pop_front()); void'(dur_q.pop_front()); void'(tag_q.pop_front());
        seg_cnt = 0;
      end
    end
  end

  always @(negedge clk) begin
    logic  empty, e_out;
    string tg;
    if (rst_n) begin
      empty = (lvl_q.size() == 0);
      e_out = empty ? 1'b1 : lvl_q[0][0];
      tg    = empty ? "R1" : tag_q[0];
      if (line_ctrl[1]) begin e_out = 1'b0; tg = "R8"; end
      chk(tx_out, e_out, tg, "tx_out");
      chk(tx_ready, empty, "R9", "tx_ready");
      chk(tx_busy, !empty, "R9", "tx_busy");
    end
  end

  task automatic send(input logic [7:1] lc, input logic [7:0] d);
    @(negedge clk); #1;
    line_ctrl = lc; tx_data = d; tx_valid = 1'b1;
    while (!tx_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_out, 1'b1, "R1", "reset tx_out");
    chk(tx_ready, 1'b1, "R1", "reset tx_ready");
    chk(tx_busy, 1'b0, "R1", "reset tx_busy");
    #1 rst_n = 1'b1;

    scen = "R2";
    send(7'b1100000, 8'h00);
    send(7'b1100000, 8'hFF);
    send(7'b1100000, 8'h01);
    send(7'b1100000, 8'h80);

    // sweep: length x parity mode x stop; back-to-back sends
    for (int s = 0; s < 4; s++)
      for (int pm = 0; pm < 5; pm++)
        for (int st = 0; st < 2; st++) begin
          logic [7:1] lc;
          logic [2:0] pbits;
          case (pm)
            0: pbits = 3'b011;
            1: pbits = 3'b100;
            2: pbits = 3'b110;
            3: pbits = 3'b111;
            default: pbits = 3'b101;
          endcase
          lc = {2'(s), 1'(st), pbits, 1'b0};
          scen = (pm == 0) ? "R6" : ((pm < 3) ? "R4" : "R5");
          send(lc, 8'(8'hC3 + s * 29 + pm * 71 + st * 13));
        end
    wait_idle();

    scen = "R8";
    send(7'b1111000, 8'h5A);
    repeat (60) @(negedge clk);
    #1 line_ctrl[1] = 1'b1;
    repeat (150) @(negedge clk);
    #1 line_ctrl[1] = 1'b0;
    wait_idle();
    send(7'b0000010, 8'h13);
    wait_idle();
    #1 line_ctrl[1] = 1'b0;

    scen = "R10";
    send(7'b1110100, 8'hA7);
    repeat (40) @(negedge clk);
    #1 line_ctrl = 7'b0011100;
    repeat (200) @(negedge clk);
    #1 line_ctrl = 7'b0100000;
    wait_idle();
    send(7'b0010000, 8'hF6);
    wait_idle();

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule